// File: doc/BRIEF.md
# JTAG Command-Stream Scan Engine

This block runs a JTAG chain from a packed stream of command bytes instead of having software toggle pins. Software writes the stream through a small register bus into a byte write FIFO, using a 1-byte, 2-byte or 4-byte push address. A sequencer pops bytes, decodes two instruction kinds and drives TCK, TMS and TDI on whichever of the chain ports is selected. The first kind walks the TAP state machine with a short TMS pattern. The second shifts a payload of up to 128 bits through TDI and can capture TDO.

Captured TDO bits are packed least-significant bit first into 32-bit words. These words queue in a read FIFO that software drains through the 4-byte push address. A status word reports whether the sequencer is busy and how full the write FIFO is. Software polls it until all of those bits read zero. A control bit drives an active-low TAP reset line. TCK comes from the system clock through a programmable divider.

Top module: `jce_top`

## Requirements
- R1: After reset, every chain output is 0, `tap_trst_n_o` is 1, the status word reads 0, the port-enable register reads 0 and the divider register reads 0.
- R2: Word address 4 pushes the byte bus_wdata[7:0]. Address 5 pushes bytes [7:0] then [15:8], and the upper bits are ignored. Address 6 pushes [7:0], [15:8], [23:16] and [31:24] in that order. A push that does not fit in the free space of the write FIFO is dropped whole.
- R3: A read of word address 0 returns bit 31 = sequencer busy, bits 30:28 = write FIFO occupancy (saturating at 7) and bit 1 = TAP reset control. All other bits are 0.
- R4: A write to address 0 sets the TAP reset control from bus_wdata[1]. `tap_trst_n_o` equals its inverse from the next cycle on.
- R5: Address 1 holds the port-enable register and reads back. A write with more than one bit set is ignored. Only enabled ports carry TCK, TMS and TDI, the others stay 0, and TDO is taken from the enabled port.
- R6: Address 2 holds the divider DIV. Each TCK half period lasts DIV+1 system clocks. TCK rests low, TMS and TDI never change while TCK is high, and TDO is sampled when TCK rises.
- R7: A command byte with bit 7 = 0 is a TMS walk with a pattern in bits 5:0. Its bits are driven on TMS least-significant bit first, one per TCK. The highest set bit is an end marker and is not driven, so 0x3F gives five high clocks, 0x12 gives 0,1,0,0, and 0x00 or 0x01 give no clocks.
- R8: A command byte with bit 7 = 1 and bit 4 = 1 is followed by a length byte. Its bits 6:0 hold the bit count minus one. Then come ceil(count/8) data bytes whose bits are shifted out on TDI least-significant bit first, one per TCK.
- R9: During a payload, TMS is 0 for every bit except the last, where it is 1.
- R10: When the command's bits 3:0 equal 4, the TDO bit of payload bit k lands in bit k mod 32 of captured word k/32. A word is queued when full or at the end of the payload, with unused upper bits 0. A read of address 6 returns and removes the oldest word, or 0 when none is queued.
- R11: Bits 3:0 other than 4 shift without capturing anything. A command byte with bit 7 = 1 and bit 4 = 0 produces no TCK clocks and consumes no further bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on bus_rdata the next cycle |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| chain_tck_o | output | NPORTS | Per-port test clock |
| chain_tms_o | output | NPORTS | Per-port test mode select |
| chain_tdi_o | output | NPORTS | Per-port test data in |
| chain_tdo_i | input | NPORTS | Per-port test data out from the chain |
| tap_trst_n_o | output | 1 | Active-low TAP reset |

## Verification
The checker assumes that software changes the port-enable and divider registers only while the sequencer is idle. It also assumes that no push is issued while the FIFO lacks room, except where a drop is provoked on purpose. Without the first assumption, a chain output could change while TCK is high and break the stability property. The bench sets enables and the divider only after polling the status word to zero. Before each push it reads the occupancy and waits until the push fits. The one over-full push is issued deliberately, while a slow TMS walk holds the sequencer busy.

// File: rtl/jce_pkg.sv
package jce_pkg;

  localparam logic [2:0] A_CSR   = 3'd0;
  localparam logic [2:0] A_PORT  = 3'd1;
  localparam logic [2:0] A_DIV   = 3'd2;
  localparam logic [2:0] A_PUSH1 = 3'd4;
  localparam logic [2:0] A_PUSH2 = 3'd5;
  localparam logic [2:0] A_PUSH4 = 3'd6;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_TMS   = 3'd1,
    SQ_LEN   = 3'd2,
    SQ_FETCH = 3'd3,
    SQ_BIT   = 3'd4
  } sq_state_t;

  typedef struct packed {
    sq_state_t   st;
    logic [5:0]  pat;
    logic        cap;
    logic [7:0]  left;
    logic [7:0]  sh;
    logic [2:0]  bidx;
    logic        ph;
    logic        tck;
    logic        tms;
    logic        tdi;
    logic [31:0] word;
    logic [4:0]  wcnt;
  } sq_regs_t;

endpackage

// File: rtl/jce_tck_gen.sv
module jce_tck_gen #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/jce_wfifo.sv
module jce_wfifo #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    push_n,
  input  logic [31:0]   push_data,
  input  logic          pop,
  output logic [7:0]    head,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          accept, do_pop;

  assign empty = (cnt_q == '0);
  assign head  = mem[rp_q];
  assign count = cnt_q;

  always_comb begin
    accept = (push_n != 3'd0) && (int'(push_n) <= DEPTH - int'(cnt_q));
    do_pop = pop && !empty;
    wp_d   = accept ? wp_q + AW'(push_n) : wp_q;
    rp_d   = do_pop ? rp_q + AW'(1) : rp_q;
    cnt_d  = cnt_q + (accept ? CW'(push_n) : '0) - CW'(do_pop);
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < 4; k++) begin
      if (accept && k < int'(push_n)) mem[wp_q + AW'(k)] <= push_data[8*k +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      wp_q <= wp_d; rp_q <= rp_d; cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/jce_rfifo.sv
module jce_rfifo #(
  parameter int DEPTH = 4,
  parameter int W = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty = (cnt_q == '0);
  assign rdata = mem[rp_q];

  always_comb begin
    do_push = push && (int'(cnt_q) < DEPTH);
    do_pop  = pop && !empty;
    wp_d    = do_push ? wp_q + AW'(1) : wp_q;
    rp_d    = do_pop ? rp_q + AW'(1) : rp_q;
    cnt_d   = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      wp_q <= wp_d; rp_q <= rp_d; cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/jce_seq.sv
module jce_seq
  import jce_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  wf_head,
  input  logic        wf_empty,
  input  logic        tick,
  input  logic        tdo,
  output logic        wf_pop,
  output logic        run,
  output logic        active,
  output logic        tck,
  output logic        tms,
  output logic        tdi,
  output logic        cap_push,
  output logic [31:0] cap_word
);
  sq_regs_t q, d;

  assign run      = (q.st == SQ_TMS) || (q.st == SQ_BIT);
  assign active   = (q.st != SQ_IDLE);
  assign tck      = q.tck;
  assign tms      = q.tms;
  assign tdi      = q.tdi;
  assign cap_word = q.word;

  always_comb begin
    d        = q;
    wf_pop   = 1'b0;
    cap_push = 1'b0;
    unique case (q.st)
      SQ_IDLE: if (!wf_empty) begin
        wf_pop = 1'b1;
        if (!wf_head[7]) begin
          if (wf_head[5:1] != 5'd0) begin
            d.pat = wf_head[5:0];
            d.tms = wf_head[0];
            d.ph  = 1'b0;
            d.st  = SQ_TMS;
          end
        end else if (wf_head[4]) begin
          d.cap = (wf_head[3:0] == 4'd4);
          d.st  = SQ_LEN;
        end
      end
      SQ_TMS: if (tick) begin
        if (!q.ph) begin
          d.tck = 1'b1;
          d.ph  = 1'b1;
        end else begin
          d.tck = 1'b0;
          d.ph  = 1'b0;
          d.pat = q.pat >> 1;
          if (d.pat == 6'd1) d.st  = SQ_IDLE;
          else               d.tms = d.pat[0];
        end
      end
      SQ_LEN: if (!wf_empty) begin
        wf_pop = 1'b1;
        d.left = {1'b0, wf_head[6:0]} + 8'd1;
        d.word = '0;
        d.wcnt = '0;
        d.st   = SQ_FETCH;
      end
      SQ_FETCH: if (!wf_empty) begin
        wf_pop = 1'b1;
        d.sh   = wf_head;
        d.tdi  = wf_head[0];
        d.tms  = (q.left == 8'd1);
        d.bidx = '0;
        d.ph   = 1'b0;
        d.st   = SQ_BIT;
      end
      SQ_BIT: if (tick) begin
        if (!q.ph) begin
          d.tck = 1'b1;
          d.ph  = 1'b1;
          if (q.cap) d.word[q.wcnt] = tdo;
        end else begin
          d.tck  = 1'b0;
          d.ph   = 1'b0;
          d.left = q.left - 8'd1;
          d.wcnt = q.wcnt + 5'd1;
          if (q.cap && (q.wcnt == 5'd31 || q.left == 8'd1)) begin
            cap_push = 1'b1;
            d.word   = '0;
          end
          if (q.left == 8'd1)      d.st = SQ_IDLE;
          else if (q.bidx == 3'd7) d.st = SQ_FETCH;
          else begin
            d.sh   = q.sh >> 1;
            d.tdi  = q.sh[1];
            d.tms  = (q.left == 8'd2);
            d.bidx = q.bidx + 3'd1;
          end
        end
      end
      default: d.st = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/jce_top.sv
module jce_top
  import jce_pkg::*;
#(
  parameter int NPORTS   = 8,
  parameter int WF_DEPTH = 8,
  parameter int RF_DEPTH = 4,
  parameter int DIV_W    = 8,
  localparam int WCW     = $clog2(WF_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NPORTS-1:0] chain_tck_o,
  output logic [NPORTS-1:0] chain_tms_o,
  output logic [NPORTS-1:0] chain_tdi_o,
  input  logic [NPORTS-1:0] chain_tdo_i,
  output logic              tap_trst_n_o
);
  logic [NPORTS-1:0] en_q, en_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              trst_q, trst_d;
  logic [31:0]       rdata_q, rdata_d;
  logic [2:0]        push_n, occ;
  logic [WCW-1:0]    wf_count;
  logic [7:0]        wf_head;
  logic              wf_empty, wf_pop, tick, run, active;
  logic              tck, tms, tdi, tdo, cap_push, rf_pop, rf_empty;
  logic [31:0]       cap_word, rf_rdata;

  always_comb begin
    push_n = 3'd0;
    if (bus_wr) begin
      if      (bus_addr == A_PUSH1) push_n = 3'd1;
      else if (bus_addr == A_PUSH2) push_n = 3'd2;
      else if (bus_addr == A_PUSH4) push_n = 3'd4;
    end
    rf_pop = bus_rd && (bus_addr == A_PUSH4);
    occ    = (int'(wf_count) > 7) ? 3'd7 : 3'(wf_count);

    en_d   = en_q;
    div_d  = div_q;
    trst_d = trst_q;
    if (bus_wr && bus_addr == A_PORT && $onehot0(bus_wdata[NPORTS-1:0]))
      en_d = bus_wdata[NPORTS-1:0];
    if (bus_wr && bus_addr == A_DIV) div_d = bus_wdata[DIV_W-1:0];
    if (bus_wr && bus_addr == A_CSR) trst_d = bus_wdata[1];

    unique case (bus_addr)
      A_CSR:   rdata_d = {active, occ, 26'd0, trst_q, 1'b0};
      A_PORT:  rdata_d = 32'(en_q);
      A_DIV:   rdata_d = 32'(div_q);
      A_PUSH4: rdata_d = rf_empty ? 32'd0 : rf_rdata;
      default: rdata_d = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; div_q <= '0; trst_q <= 1'b0; rdata_q <= '0;
    end else begin
      en_q   <= en_d;
      div_q  <= div_d;
      trst_q <= trst_d;
      if (bus_rd) rdata_q <= rdata_d;
    end
  end

  jce_wfifo #(.DEPTH(WF_DEPTH)) u_wfifo (
    .clk, .rst_n, .push_n, .push_data(bus_wdata), .pop(wf_pop),
    .head(wf_head), .empty(wf_empty), .count(wf_count)
  );

  jce_tck_gen #(.DW(DIV_W)) u_tck (
    .clk, .rst_n, .run, .div(div_q), .tick
  );

  jce_seq u_seq (
    .clk, .rst_n, .wf_head, .wf_empty, .tick, .tdo, .wf_pop, .run, .active,
    .tck, .tms, .tdi, .cap_push, .cap_word
  );

  jce_rfifo #(.DEPTH(RF_DEPTH), .W(32)) u_rfifo (
    .clk, .rst_n, .push(cap_push), .wdata(cap_word), .pop(rf_pop),
    .rdata(rf_rdata), .empty(rf_empty)
  );

  assign tdo          = |(chain_tdo_i & en_q);
  assign chain_tck_o  = tck ? en_q : '0;
  assign chain_tms_o  = tms ? en_q : '0;
  assign chain_tdi_o  = tdi ? en_q : '0;
  assign tap_trst_n_o = !trst_q;
  assign bus_rdata    = rdata_q;
endmodule

// File: rtl/jce_chk.sv
module jce_chk #(
  parameter int NPORTS   = 8,
  parameter int WF_DEPTH = 8,
  localparam int WCW     = $clog2(WF_DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [2:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [NPORTS-1:0] chain_tck_o,
  input logic [NPORTS-1:0] chain_tms_o,
  input logic [NPORTS-1:0] chain_tdi_o,
  input logic              tap_trst_n_o,
  input logic              active,
  input logic [WCW-1:0]    wf_count,
  input logic [NPORTS-1:0] en_q
);
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wf_count) <= WF_DEPTH);

  p_trst_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0) |=> (tap_trst_n_o == !$past(bus_wdata[1])));

  p_multi_en_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd1 && $countones(bus_wdata[NPORTS-1:0]) > 1) |=> $stable(en_q));

  p_tck_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chain_tck_o));

  p_quiet_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (chain_tck_o == '0));

  p_stable_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|chain_tck_o) |-> ($stable(chain_tms_o) && $stable(chain_tdi_o)));
endmodule

bind jce_top jce_chk #(.NPORTS(NPORTS), .WF_DEPTH(WF_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .chain_tck_o(chain_tck_o), .chain_tms_o(chain_tms_o),
  .chain_tdi_o(chain_tdi_o), .tap_trst_n_o(tap_trst_n_o), .active(active),
  .wf_count(wf_count), .en_q(en_q)
);

// File: tb/jce_top_tb_top.sv
module jce_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr, bus_rd;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  chain_tck_o, chain_tms_o, chain_tdi_o, chain_tdo_i;
  logic        tap_trst_n_o;

  int n_vec = 0, n_bad = 0;
  int edge_n = 0, stray = 0, hi_cnt = 0, last_hi = 0;
  logic log_tms [8192];
  logic log_tdi [8192];
  logic [7:0] bb [64];
  int nb;

  always #2 clk = ~clk;

  jce_top dut_i (
    .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
    .chain_tck_o, .chain_tms_o, .chain_tdi_o, .chain_tdo_i, .tap_trst_n_o
  );

  function automatic logic pbit(int n);
    logic [31:0] h;
    h = 32'(n) * 32'h9E3779B1;
    return h[13];
  endfunction

  // chain model on port 7; TDO advances after each rising TCK
  assign chain_tdo_i = {pbit(edge_n), 7'h55};
  always @(posedge chain_tck_o[7]) begin
    log_tms[edge_n % 8192] = chain_tms_o[7];
    log_tdi[edge_n % 8192] = chain_tdi_o[7];
    edge_n = edge_n + 1;
  end

  always @(negedge clk) begin
    if (chain_tck_o[6:0] != 7'd0) stray++;
    if (chain_tck_o[7]) hi_cnt++;
    else if (hi_cnt != 0) begin last_hi = hi_cnt; hi_cnt = 0; end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    do rd(3'd0, s); while (s[31:28] != 4'd0);
  endtask

  task automatic flush();
    int i = 0;
    while (i < nb) begin
      int sz;
      logic [31:0] s, w;
      sz = 1 << ($urandom % 3);
      while (sz > nb - i) sz = sz >> 1;
      do rd(3'd0, s); while (int'(s[30:28]) + sz > 7);
      w = {bb[(i+3)%64], bb[(i+2)%64], bb[(i+1)%64], bb[i]};
      wr(sz == 4 ? 3'd6 : (sz == 2 ? 3'd5 : 3'd4), w);
      i += sz;
    end
  endtask

  task automatic do_tms(input logic [5:0] arg);
    int start, n_exp, bad;
    start = edge_n; n_exp = 0; bad = 0;
    for (int b = 0; b < 6; b++) if (arg[b]) n_exp = b;
    nb = 1; bb[0] = {2'b00, arg};
    flush(); wait_idle();
    chk(edge_n - start == n_exp, "R7 tms clock count", 32'(edge_n - start), 32'(n_exp));
    for (int b = 0; b < n_exp; b++) if (log_tms[(start + b) % 8192] != arg[b]) bad++;
    chk(bad == 0, "R7 tms bit order", 32'(bad), 32'd0);
  endtask

  task automatic do_shift(input int len, input logic [127:0] data, input bit cap);
    int start, bad_tdi, bad_tms, nw;
    logic [31:0] v, e;
    start = edge_n; bad_tdi = 0; bad_tms = 0;
    bb[0] = cap ? 8'h94 : 8'h90;
    bb[1] = 8'(len - 1);
    nb = 2 + (len + 7) / 8;
    for (int i = 0; i < (len + 7) / 8; i++) bb[2 + i] = data[8*i +: 8];
    flush(); wait_idle();
    chk(edge_n - start == len, "R8 payload clock count", 32'(edge_n - start), 32'(len));
    for (int k = 0; k < len; k++) begin
      if (log_tdi[(start + k) % 8192] != data[k]) bad_tdi++;
      if (log_tms[(start + k) % 8192] != (k == len - 1)) bad_tms++;
    end
    chk(bad_tdi == 0, "R8 tdi lsb-first order", 32'(bad_tdi), 32'd0);
    chk(bad_tms == 0, "R9 tms low then high on last bit", 32'(bad_tms), 32'd0);
    nw = cap ? (len + 31) / 32 : 0;
    for (int w = 0; w < nw; w++) begin
      e = '0;
      for (int b = 0; b < 32; b++) if (w*32 + b < len) e[b] = pbit(start + w*32 + b);
      rd(3'd6, v);
      chk(v == e, "R10 captured word", v, e);
    end
    rd(3'd6, v);
    chk(v == 32'd0, cap ? "R10 empty read gives zero" : "R11 no capture when arg is 0", v, 32'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    int start;
    void'($urandom(32'h5EED1234));
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 3'd0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    chk(chain_tck_o == 8'd0 && chain_tms_o == 8'd0 && chain_tdi_o == 8'd0, "R1 chain idle in reset",
        32'({chain_tck_o, chain_tms_o, chain_tdi_o}), 32'd0);
    chk(tap_trst_n_o == 1'b1, "R1 trst released in reset", 32'(tap_trst_n_o), 32'd1);
    rst_n = 1'b1;
    rd(3'd0, v); chk(v == 32'd0, "R1 status after reset", v, 32'd0);
    rd(3'd1, v); chk(v == 32'd0, "R1 enable after reset", v, 32'd0);
    rd(3'd2, v); chk(v == 32'd0, "R1 divider after reset", v, 32'd0);

    wr(3'd1, 32'h80); wr(3'd2, 32'd1);
    rd(3'd1, v); chk(v == 32'h80, "R5 enable readback", v, 32'h80);
    wr(3'd1, 32'h03);
    rd(3'd1, v); chk(v == 32'h80, "R5 multi-bit enable ignored", v, 32'h80);

    wr(3'd0, 32'h2);
    chk(tap_trst_n_o == 1'b0, "R4 trst asserted", 32'(tap_trst_n_o), 32'd0);
    rd(3'd0, v); chk(v == 32'h2, "R3 status shows reset control", v, 32'h2);
    wr(3'd0, 32'h0);
    chk(tap_trst_n_o == 1'b1, "R4 trst released", 32'(tap_trst_n_o), 32'd1);

    do_tms(6'h3F);
    chk(last_hi == 2, "R6 tck high time at DIV=1", 32'(last_hi), 32'd2);
    do_tms(6'h12); do_tms(6'h01); do_tms(6'h00);
    for (int i = 0; i < 6; i++) do_tms(6'($urandom % 64));

    // little-endian 4-byte push: 0x03 then 0x12 then two 0x00 -> 1,0,1,0,0
    start = edge_n;
    wr(3'd6, 32'h0000_1203); wait_idle();
    chk(edge_n - start == 5, "R2 4-byte push count", 32'(edge_n - start), 32'd5);
    chk({log_tms[start], log_tms[start+1], log_tms[start+2], log_tms[start+3], log_tms[start+4]} == 5'b10100,
        "R2 4-byte push byte order",
        32'({log_tms[start], log_tms[start+1], log_tms[start+2], log_tms[start+3], log_tms[start+4]}), 32'b10100);
    start = edge_n;
    wr(3'd5, 32'hFF05_1203); wait_idle();
    chk(edge_n - start == 4 + 1, "R2 2-byte push ignores upper half", 32'(edge_n - start), 32'd5);
    start = edge_n;
    wr(3'd4, 32'h0000_0084); wait_idle();
    chk(edge_n == start, "R11 no-payload command gives no clocks", 32'(edge_n - start), 32'd0);

    do_shift(1, 128'h1, 1'b1);
    do_shift(32, {96'd0, 32'hA5C3_0F96}, 1'b1);
    do_shift(33, {95'd0, 33'h1_DEAD_BEEF}, 1'b1);
    do_shift(128, {$urandom, $urandom, $urandom, $urandom}, 1'b1);
    do_shift(40, {$urandom, $urandom, $urandom, $urandom}, 1'b0);
    for (int i = 0; i < 10; i++)
      do_shift(1 + int'($urandom % 128), {$urandom, $urandom, $urandom, $urandom}, 1'($urandom % 2));

    // occupancy, drop on overflow and divider with a slow walk
    wr(3'd2, 32'd20);
    start = edge_n;
    wr(3'd4, 32'h3F);
    repeat (3) @(negedge clk);
    wr(3'd6, 32'h3F3F_3F3F);
    rd(3'd0, v);
    chk(v[31] == 1'b1, "R3 busy flag while walking", 32'(v[31]), 32'd1);
    chk(v[30:28] == 3'd4, "R3 occupancy after 4-byte push", 32'(v[30:28]), 32'd4);
    wr(3'd5, 32'h0000_3F3F);
    rd(3'd0, v); chk(v[30:28] == 3'd6, "R3 occupancy after 2-byte push", 32'(v[30:28]), 32'd6);
    wr(3'd6, 32'h3F3F_3F3F);
    rd(3'd0, v); chk(v[30:28] == 3'd6, "R2 oversize push dropped", 32'(v[30:28]), 32'd6);
    wait_idle();
    chk(edge_n - start == 35, "R2 only accepted bytes executed", 32'(edge_n - start), 32'd35);
    chk(last_hi == 21, "R6 tck high time at DIV=20", 32'(last_hi), 32'd21);
    rd(3'd0, v); chk(v == 32'd0, "R3 idle status after run", v, 32'd0);
    chk(stray == 0, "R5 unselected ports stay quiet", 32'(stray), 32'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule